// File: doc/BRIEF.md
# Effective Address Sequencer

This block sits between an instruction decoder and a byte-wide memory read port. The decoder hands it an addressing-mode code, the program counter pointing just past the opcode, and the two index registers. The sequencer then fetches the operand field from memory, one byte at a time, follows any pointer held in memory, and applies indexing or a signed branch offset. It returns the effective address, the operand byte and the program counter advanced past the operand field. A one-cycle done pulse marks the moment these results become valid.

Memory is reached through a single read port: the sequencer raises a read request with an address and holds both until the memory answers with a valid strobe. A raw-field flag makes the sequencer return the operand field exactly as fetched, with no index added, no pointer followed and no data read. A disassembler uses this flag. Mode codes outside the defined set raise an error flag. They finish without touching memory.

Top module: `amseq_top`

## Requirements
- R1: After reset, done, modeErr and memRd are 0, and eaOut, operand and pcOut are 0.
- R2: Mode 0 (implied) and mode 1 (accumulator) read no memory. They finish with eaOut = 0, operand = 0 and pcOut = pcIn.
- R3: Mode 2 (immediate) reads one byte at pcIn. operand is that byte, eaOut is that byte zero-extended, and pcOut = pcIn + 1.
- R4: Mode 3 (page zero), mode 4 (page zero + X) and mode 5 (page zero + Y) read one field byte B at pcIn. eaOut = (B + index) mod 256, where the index is 0, X or Y. operand is the byte at eaOut, and pcOut = pcIn + 1.
- R5: Mode 6 (wide), mode 7 (wide + X) and mode 8 (wide + Y) read the field low byte at pcIn and the high byte at pcIn + 1. eaOut = (field + index) mod 2^AW. operand is the byte at eaOut, and pcOut = pcIn + 2.
- R6: Mode 9 (pointer) reads a 16-bit field P, low byte first. It then reads the target low byte at P and the high byte at P + 1. eaOut is that target, operand is the byte at the target, and pcOut = pcIn + 2.
- R7: Mode 10 (pre-indexed pointer) reads field byte B. It takes the target low byte from (B + X) mod 256 and the high byte from (B + X + 1) mod 256. eaOut is that target, operand is the byte there, and pcOut = pcIn + 1.
- R8: Mode 11 (post-indexed pointer) reads field byte B. It takes a base from B (low byte) and from (B + 1) mod 256 (high byte). eaOut = base + Y, operand is the byte there, and pcOut = pcIn + 1.
- R9: Mode 12 (branch) reads offset byte D. eaOut = pcIn + 1 + sign-extended D, operand = D, and pcOut = pcIn + 1. The raw-field flag has no effect on this mode.
- R10: With noInd = 1, modes 2 to 11 read only the field bytes. eaOut is the field zero-extended, operand is the field low byte, and pcOut advances by the field length.
- R11: Mode codes 13 to 15 read no memory. They finish with modeErr = 1, eaOut = 0, operand = 0 and pcOut = pcIn. Every defined mode finishes with modeErr = 0.
- R12: done is high for exactly one cycle per accepted start. A start that arrives while an operation is in progress is ignored.
- R13: memAddr and memRd stay stable until memValid is seen. memData is taken in the cycle when memValid is high, and bytes are read in the order the mode defines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one address computation (accepted when idle) |
| modeIn | input | 4 | Addressing-mode code |
| noInd | input | 1 | Return the raw operand field |
| pcIn | input | AW | Program counter just past the opcode |
| xIn | input | 8 | X index register |
| yIn | input | 8 | Y index register |
| memAddr | output | AW | Memory read address |
| memRd | output | 1 | Memory read request |
| memData | input | 8 | Memory read data |
| memValid | input | 1 | Read data valid |
| pcOut | output | AW | Program counter past the operand field |
| eaOut | output | AW | Effective address |
| operand | output | 8 | Operand byte |
| done | output | 1 | One-cycle completion pulse |
| modeErr | output | 1 | Last mode code was undefined |

## Verification
The bench builds the block with the default AW = 16, so that full 16-bit wraparound of wide indexing is reachable from ordinary field values. Field bytes near 0xFF exercise wraparound of page-zero indexing and of pointer fetches at both page-zero pointer bytes. The bench memory model runs with one and with four cycles of read latency, which shows that requests are held steady and that bytes are taken only on the valid strobe.

// File: rtl/amseq_pkg.sv
package amseq_pkg;

  localparam logic [3:0] MODE_NONE      = 4'd0;
  localparam logic [3:0] MODE_ACCUM     = 4'd1;
  localparam logic [3:0] MODE_IMMED     = 4'd2;
  localparam logic [3:0] MODE_PAGE0     = 4'd3;
  localparam logic [3:0] MODE_PAGE0_X   = 4'd4;
  localparam logic [3:0] MODE_PAGE0_Y   = 4'd5;
  localparam logic [3:0] MODE_WIDE      = 4'd6;
  localparam logic [3:0] MODE_WIDE_X    = 4'd7;
  localparam logic [3:0] MODE_WIDE_Y    = 4'd8;
  localparam logic [3:0] MODE_PTR       = 4'd9;
  localparam logic [3:0] MODE_PTR_PREX  = 4'd10;
  localparam logic [3:0] MODE_PTR_POSTY = 4'd11;
  localparam logic [3:0] MODE_BRANCH    = 4'd12;

  typedef enum logic [2:0] {
    SEL_OP0,
    SEL_OP1,
    SEL_PTR0,
    SEL_PTR1,
    SEL_EA
  } addrSel_t;

  typedef struct packed {
    logic     load;
    logic     capOp0;
    logic     capOp1;
    logic     capPtr0;
    logic     capPtr1;
    logic     capData;
    logic     finish;
    addrSel_t addrSel;
  } ctrlStrobe_t;

  function automatic logic modeKnown(logic [3:0] m);
    return m <= MODE_BRANCH;
  endfunction

  // number of operand field bytes following the opcode
  function automatic logic [1:0] opCount(logic [3:0] m);
    case (m)
      MODE_IMMED, MODE_PAGE0, MODE_PAGE0_X, MODE_PAGE0_Y,
      MODE_PTR_PREX, MODE_PTR_POSTY, MODE_BRANCH: return 2'd1;
      MODE_WIDE, MODE_WIDE_X, MODE_WIDE_Y, MODE_PTR: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic needsPtr(logic [3:0] m, logic raw);
    return !raw && (m == MODE_PTR || m == MODE_PTR_PREX || m == MODE_PTR_POSTY);
  endfunction

  function automatic logic needsData(logic [3:0] m, logic raw);
    return !raw && (m >= MODE_PAGE0) && (m <= MODE_PTR_POSTY);
  endfunction

  function automatic logic isPage0(logic [3:0] m);
    return m == MODE_PAGE0 || m == MODE_PAGE0_X || m == MODE_PAGE0_Y;
  endfunction

endpackage

// File: rtl/amseq_ctrl.sv
module amseq_ctrl
  import amseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  modeIn,
  input  logic [3:0]  modeQ,
  input  logic        noIndQ,
  input  logic        memValid,
  output ctrlStrobe_t ctrl,
  output logic        memRd,
  output logic        done
);

  typedef enum logic [2:0] {
    S_IDLE, S_OP0, S_OP1, S_PTR0, S_PTR1, S_DATA, S_WRAP, S_DONE
  } state_t;

  state_t state, stateNext;

  logic qPtr, qData;
  logic [1:0] qOps;

  always_comb begin
    qPtr  = needsPtr(modeQ, noIndQ);
    qData = needsData(modeQ, noIndQ);
    qOps  = opCount(modeQ);
  end

  function automatic state_t afterField(logic p, logic d);
    if (p) return S_PTR0;
    if (d) return S_DATA;
    return S_WRAP;
  endfunction

  always_comb begin
    stateNext    = state;
    ctrl         = '0;
    ctrl.addrSel = SEL_OP0;
    memRd        = 1'b0;
    done         = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctrl.load = 1'b1;
          stateNext = (opCount(modeIn) != 2'd0) ? S_OP0 : S_WRAP;
        end
      end
      S_OP0: begin
        memRd        = 1'b1;
        ctrl.addrSel = SEL_OP0;
        if (memValid) begin
          ctrl.capOp0 = 1'b1;
          stateNext   = (qOps == 2'd2) ? S_OP1 : afterField(qPtr, qData);
        end
      end
      S_OP1: begin
        memRd        = 1'b1;
        ctrl.addrSel = SEL_OP1;
        if (memValid) begin
          ctrl.capOp1 = 1'b1;
          stateNext   = afterField(qPtr, qData);
        end
      end
      S_PTR0: begin
        memRd        = 1'b1;
        ctrl.addrSel = SEL_PTR0;
        if (memValid) begin
          ctrl.capPtr0 = 1'b1;
          stateNext    = S_PTR1;
        end
      end
      S_PTR1: begin
        memRd        = 1'b1;
        ctrl.addrSel = SEL_PTR1;
        if (memValid) begin
          ctrl.capPtr1 = 1'b1;
          stateNext    = qData ? S_DATA : S_WRAP;
        end
      end
      S_DATA: begin
        memRd        = 1'b1;
        ctrl.addrSel = SEL_EA;
        if (memValid) begin
          ctrl.capData = 1'b1;
          stateNext    = S_WRAP;
        end
      end
      S_WRAP: begin
        ctrl.finish = 1'b1;
        stateNext   = S_DONE;
      end
      S_DONE: begin
        done      = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R12: completion is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: an undefined mode never reaches the memory port
  a_r11_no_read_unknown: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && !modeKnown(modeQ)) |-> !memRd);

  // R10: raw-field requests never chase pointers
  a_r10_raw_no_ptr: assert property (@(posedge clk) disable iff (!rstN)
    (noIndQ && state != S_IDLE) |-> !(ctrl.capPtr0 || ctrl.capPtr1 || ctrl.capData));

endmodule

// File: rtl/amseq_dp.sv
module amseq_dp
  import amseq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   ctrl,
  input  logic [3:0]    modeIn,
  input  logic          noInd,
  input  logic [AW-1:0] pcIn,
  input  logic [7:0]    xIn,
  input  logic [7:0]    yIn,
  input  logic [7:0]    memData,
  output logic [AW-1:0] memAddr,
  output logic [3:0]    modeQ,
  output logic          noIndQ,
  output logic [AW-1:0] pcOut,
  output logic [AW-1:0] eaOut,
  output logic [7:0]    operand,
  output logic          modeErr
);

  localparam int PAGE_W = 8;
  localparam int HI_W   = AW - PAGE_W;

  logic [AW-1:0] pcBase;
  logic [7:0]    xQ, yQ, opLo, opHi, ptLo, ptHi, dataQ;

  function automatic logic [AW-1:0] inPage0(logic [7:0] b);
    return {{HI_W{1'b0}}, b};
  endfunction

  logic [AW-1:0] field, ptrWord, branchTgt, eaCalc, ptr0Addr, ptr1Addr, pcNext;
  logic [7:0]    preX, operandNext;

  always_comb begin
    field     = {{(AW-16){1'b0}}, opHi, opLo};
    ptrWord   = {{(AW-16){1'b0}}, ptHi, ptLo};
    preX      = opLo + xQ;
    branchTgt = pcBase + AW'(1) + {{HI_W{opLo[7]}}, opLo};

    case (modeQ)
      MODE_IMMED, MODE_PAGE0: eaCalc = inPage0(opLo);
      MODE_PAGE0_X:   eaCalc = noIndQ ? inPage0(opLo) : inPage0(opLo + xQ);
      MODE_PAGE0_Y:   eaCalc = noIndQ ? inPage0(opLo) : inPage0(opLo + yQ);
      MODE_WIDE:      eaCalc = field;
      MODE_WIDE_X:    eaCalc = noIndQ ? field : field + AW'(xQ);
      MODE_WIDE_Y:    eaCalc = noIndQ ? field : field + AW'(yQ);
      MODE_PTR:       eaCalc = noIndQ ? field : ptrWord;
      MODE_PTR_PREX:  eaCalc = noIndQ ? inPage0(opLo) : ptrWord;
      MODE_PTR_POSTY: eaCalc = noIndQ ? inPage0(opLo) : ptrWord + AW'(yQ);
      MODE_BRANCH:    eaCalc = branchTgt;
      default:        eaCalc = '0;
    endcase

    case (modeQ)
      MODE_PTR: begin
        ptr0Addr = field;
        ptr1Addr = field + AW'(1);
      end
      MODE_PTR_PREX: begin
        ptr0Addr = inPage0(preX);
        ptr1Addr = inPage0(preX + 8'd1);
      end
      default: begin
        ptr0Addr = inPage0(opLo);
        ptr1Addr = inPage0(opLo + 8'd1);
      end
    endcase

    case (ctrl.addrSel)
      SEL_OP1:  memAddr = pcBase + AW'(1);
      SEL_PTR0: memAddr = ptr0Addr;
      SEL_PTR1: memAddr = ptr1Addr;
      SEL_EA:   memAddr = eaCalc;
      default:  memAddr = pcBase;
    endcase

    if (needsData(modeQ, noIndQ))       operandNext = dataQ;
    else if (opCount(modeQ) != 2'd0)    operandNext = opLo;
    else                                operandNext = 8'd0;

    pcNext = pcBase + AW'(opCount(modeQ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      noIndQ <= 1'b0;
      pcBase <= '0;
      xQ     <= '0;
      yQ     <= '0;
      opLo   <= '0;
      opHi   <= '0;
      ptLo   <= '0;
      ptHi   <= '0;
      dataQ  <= '0;
    end else begin
      if (ctrl.load) begin
        modeQ  <= modeIn;
        noIndQ <= noInd;
        pcBase <= pcIn;
        xQ     <= xIn;
        yQ     <= yIn;
        opLo   <= '0;
        opHi   <= '0;
        ptLo   <= '0;
        ptHi   <= '0;
        dataQ  <= '0;
      end
      if (ctrl.capOp0)  opLo  <= memData;
      if (ctrl.capOp1)  opHi  <= memData;
      if (ctrl.capPtr0) ptLo  <= memData;
      if (ctrl.capPtr1) ptHi  <= memData;
      if (ctrl.capData) dataQ <= memData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcOut   <= '0;
      eaOut   <= '0;
      operand <= '0;
      modeErr <= 1'b0;
    end else if (ctrl.finish) begin
      pcOut   <= pcNext;
      eaOut   <= eaCalc;
      operand <= operandNext;
      modeErr <= !modeKnown(modeQ);
    end
  end

  // R4: page-zero data reads stay inside page zero
  a_r4_page0_data: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.addrSel == SEL_EA && isPage0(modeQ)) |-> (memAddr[AW-1:PAGE_W] == '0));

  // R7 / R8: page-zero pointer fetches wrap within page zero
  a_r7_page0_ptr: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrl.addrSel == SEL_PTR0 || ctrl.addrSel == SEL_PTR1) &&
     (modeQ == MODE_PTR_PREX || modeQ == MODE_PTR_POSTY)) |-> (memAddr[AW-1:PAGE_W] == '0));

  // R13: the high field byte is always fetched right after the low one
  a_r13_field_order: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capOp1 |-> (memAddr == pcBase + AW'(1)));

endmodule

// File: rtl/amseq_top.sv
module amseq_top
  import amseq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [3:0]    modeIn,
  input  logic          noInd,
  input  logic [AW-1:0] pcIn,
  input  logic [7:0]    xIn,
  input  logic [7:0]    yIn,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  input  logic [7:0]    memData,
  input  logic          memValid,
  output logic [AW-1:0] pcOut,
  output logic [AW-1:0] eaOut,
  output logic [7:0]    operand,
  output logic          done,
  output logic          modeErr
);

  ctrlStrobe_t ctrl;
  logic [3:0]  modeQ;
  logic        noIndQ;

  amseq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .modeIn   (modeIn),
    .modeQ    (modeQ),
    .noIndQ   (noIndQ),
    .memValid (memValid),
    .ctrl     (ctrl),
    .memRd    (memRd),
    .done     (done)
  );

  amseq_dp #(.AW(AW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .modeIn  (modeIn),
    .noInd   (noInd),
    .pcIn    (pcIn),
    .xIn     (xIn),
    .yIn     (yIn),
    .memData (memData),
    .memAddr (memAddr),
    .modeQ   (modeQ),
    .noIndQ  (noIndQ),
    .pcOut   (pcOut),
    .eaOut   (eaOut),
    .operand (operand),
    .modeErr (modeErr)
  );

  // R13: an outstanding request holds address and strobe until answered
  a_r13_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memValid) |=> (memRd && $stable(memAddr)));

endmodule

// File: tb/amseq_top_test.sv
module amseq_top_test;

  localparam int CLK_NS = 10;
  localparam int AW     = 16;
  localparam int WDOG   = 100000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    modeIn = '0;
  logic          noInd = 1'b0;
  logic [AW-1:0] pcIn = '0;
  logic [7:0]    xIn = '0, yIn = '0;
  logic [AW-1:0] memAddr;
  logic          memRd;
  logic [7:0]    memData = '0;
  logic          memValid = 1'b0;
  logic [AW-1:0] pcOut, eaOut;
  logic [7:0]    operand;
  logic          done, modeErr;

  always #(CLK_NS/2) clk = ~clk;

  amseq_top #(.AW(AW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn), .noInd(noInd),
    .pcIn(pcIn), .xIn(xIn), .yIn(yIn), .memAddr(memAddr), .memRd(memRd),
    .memData(memData), .memValid(memValid), .pcOut(pcOut), .eaOut(eaOut),
    .operand(operand), .done(done), .modeErr(modeErr)
  );

  int nChk = 0, nFail = 0;

  // sparse memory: override table over a computed background
  logic [15:0] ovAddr [16];
  logic [7:0]  ovData [16];
  int          ovN = 0;
  int          lat = 0;

  function automatic logic [7:0] rdByte(logic [15:0] a);
    for (int i = 0; i < 16; i++)
      if (i < ovN && ovAddr[i] == a) return ovData[i];
    return (a[7:0] + 8'h3B) ^ a[15:8];
  endfunction

  task automatic ovSet(logic [15:0] a, logic [7:0] d);
    ovAddr[ovN] = a;
    ovData[ovN] = d;
    ovN++;
  endtask

  // memory model with programmable latency and a read log
  int          waitCnt = 0;
  int          logCnt = 0;
  int          stabErr = 0;
  logic [15:0] holdAddr = '0;
  logic [15:0] logA [8];

  always @(posedge clk) begin
    memValid <= 1'b0;
    if (memRd && !memValid) begin
      if (waitCnt != 0 && memAddr != holdAddr) stabErr <= stabErr + 1;
      holdAddr <= memAddr;
      if (waitCnt >= lat) begin
        memValid          <= 1'b1;
        memData           <= rdByte(memAddr);
        logA[logCnt % 8]  <= memAddr;
        logCnt            <= logCnt + 1;
        waitCnt           <= 0;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [AW-1:0] rEa, rPc;
  logic [7:0]    rOp;
  logic          rErr, rAfter;
  int            rReads, rBase;

  task automatic runOp(logic [3:0] m, logic ni, logic [15:0] pc,
                       logic [7:0] x, logic [7:0] y, bit poke);
    int cyc;
    @(negedge clk);
    modeIn = m; noInd = ni; pcIn = pc; xIn = x; yIn = y; start = 1'b1;
    rBase = logCnt;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      start = 1'b1; modeIn = 4'd0; pcIn = 16'h0000;
      @(negedge clk);
      start = 1'b0; modeIn = m; pcIn = pc;
    end
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk("R12 done seen", int'(done), 1);
    rEa = eaOut; rPc = pcOut; rOp = operand; rErr = modeErr;
    rReads = logCnt - rBase;
    @(negedge clk);
    rAfter = done;
    chk("R12 done single cycle", int'(rAfter), 0);
  endtask

  task automatic expectAll(string tag, int ea, int op, int pc, int reads);
    chk({tag, " ea"}, int'(rEa), ea);
    chk({tag, " operand"}, int'(rOp), op);
    chk({tag, " pc"}, int'(rPc), pc);
    chk({tag, " reads"}, rReads, reads);
    chk({tag, " err"}, int'(rErr), 0);
  endtask

  task automatic testReset();
    chk("R1 done", int'(done), 0);
    chk("R1 memRd", int'(memRd), 0);
    chk("R1 err", int'(modeErr), 0);
    chk("R1 ea", int'(eaOut), 0);
    chk("R1 operand", int'(operand), 0);
    chk("R1 pc", int'(pcOut), 0);
  endtask

  task automatic testNoOperand();
    runOp(4'd0, 1'b0, 16'h0600, 8'h11, 8'h22, 0);
    expectAll("R2 implied", 0, 0, 16'h0600, 0);
    runOp(4'd1, 1'b0, 16'h0655, 8'h11, 8'h22, 0);
    expectAll("R2 accum", 0, 0, 16'h0655, 0);
  endtask

  task automatic testImmediate();
    ovSet(16'h0600, 8'h7F);
    runOp(4'd2, 1'b0, 16'h0600, 8'h00, 8'h00, 0);
    expectAll("R3 immediate", 16'h007F, 8'h7F, 16'h0601, 1);
  endtask

  task automatic testPage0();
    ovSet(16'h0700, 8'hF0);
    runOp(4'd3, 1'b0, 16'h0700, 8'h20, 8'h15, 0);
    expectAll("R4 page0", 16'h00F0, int'(rdByte(16'h00F0)), 16'h0701, 2);
    runOp(4'd4, 1'b0, 16'h0700, 8'h20, 8'h15, 0);
    expectAll("R4 page0+X wrap", 16'h0010, int'(rdByte(16'h0010)), 16'h0701, 2);
    runOp(4'd5, 1'b0, 16'h0700, 8'h20, 8'h15, 0);
    expectAll("R4 page0+Y wrap", 16'h0005, int'(rdByte(16'h0005)), 16'h0701, 2);
  endtask

  task automatic testWide();
    ovSet(16'h0800, 8'hF0);
    ovSet(16'h0801, 8'h12);
    runOp(4'd6, 1'b0, 16'h0800, 8'h30, 8'h00, 0);
    expectAll("R5 wide", 16'h12F0, int'(rdByte(16'h12F0)), 16'h0802, 3);
    runOp(4'd7, 1'b0, 16'h0800, 8'h30, 8'h00, 0);
    expectAll("R5 wide+X", 16'h1320, int'(rdByte(16'h1320)), 16'h0802, 3);
    ovSet(16'h0810, 8'hF0);
    ovSet(16'h0811, 8'hFF);
    runOp(4'd8, 1'b0, 16'h0810, 8'h00, 8'hFF, 0);
    expectAll("R5 wide+Y wrap", 16'h00EF, int'(rdByte(16'h00EF)), 16'h0812, 3);
  endtask

  task automatic testPointer();
    ovSet(16'h0900, 8'hFF);
    ovSet(16'h0901, 8'h30);
    ovSet(16'h30FF, 8'h34);
    ovSet(16'h3100, 8'h12);
    runOp(4'd9, 1'b0, 16'h0900, 8'h00, 8'h00, 1);
    expectAll("R6 pointer (R12 busy start ignored)", 16'h1234,
              int'(rdByte(16'h1234)), 16'h0902, 5);
    chk("R13 order field lo", int'(logA[rBase % 8]), 16'h0900);
    chk("R13 order field hi", int'(logA[(rBase + 1) % 8]), 16'h0901);
    chk("R6 ptr lo addr", int'(logA[(rBase + 2) % 8]), 16'h30FF);
    chk("R6 ptr hi addr", int'(logA[(rBase + 3) % 8]), 16'h3100);
    chk("R6 data addr", int'(logA[(rBase + 4) % 8]), 16'h1234);
  endtask

  task automatic testPreX();
    ovSet(16'h0A00, 8'hFE);
    ovSet(16'h00FF, 8'h78);
    ovSet(16'h0000, 8'h56);
    runOp(4'd10, 1'b0, 16'h0A00, 8'h01, 8'h00, 0);
    expectAll("R7 pre-indexed", 16'h5678, int'(rdByte(16'h5678)), 16'h0A01, 4);
    chk("R7 ptr hi wraps", int'(logA[(rBase + 2) % 8]), 16'h0000);
  endtask

  task automatic testPostY();
    ovSet(16'h0B00, 8'hFF);
    runOp(4'd11, 1'b0, 16'h0B00, 8'h00, 8'h20, 0);
    expectAll("R8 post-indexed", 16'h5698, int'(rdByte(16'h5698)), 16'h0B01, 4);
    chk("R8 ptr lo addr", int'(logA[(rBase + 1) % 8]), 16'h00FF);
    chk("R8 ptr hi wraps", int'(logA[(rBase + 2) % 8]), 16'h0000);
  endtask

  task automatic testBranch();
    ovSet(16'h0C10, 8'h80);
    ovSet(16'h0C20, 8'h05);
    runOp(4'd12, 1'b0, 16'h0C10, 8'h00, 8'h00, 0);
    expectAll("R9 branch back", 16'h0B91, 8'h80, 16'h0C11, 1);
    runOp(4'd12, 1'b1, 16'h0C20, 8'h00, 8'h00, 0);
    expectAll("R9 branch fwd raw flag", 16'h0C26, 8'h05, 16'h0C21, 1);
  endtask

  task automatic testRaw();
    runOp(4'd10, 1'b1, 16'h0A00, 8'h01, 8'h00, 0);
    expectAll("R10 raw pre-indexed", 16'h00FE, 8'hFE, 16'h0A01, 1);
    runOp(4'd7, 1'b1, 16'h0800, 8'h30, 8'h00, 0);
    expectAll("R10 raw wide+X", 16'h12F0, 8'hF0, 16'h0802, 2);
    runOp(4'd9, 1'b1, 16'h0900, 8'h00, 8'h00, 0);
    expectAll("R10 raw pointer", 16'h30FF, 8'hFF, 16'h0902, 2);
  endtask

  task automatic testUnknown();
    runOp(4'd13, 1'b0, 16'h0D00, 8'h00, 8'h00, 0);
    chk("R11 err 13", int'(rErr), 1);
    chk("R11 reads 13", rReads, 0);
    chk("R11 ea 13", int'(rEa), 0);
    chk("R11 operand 13", int'(rOp), 0);
    chk("R11 pc 13", int'(rPc), 16'h0D00);
    runOp(4'd15, 1'b0, 16'h0D40, 8'h00, 8'h00, 0);
    chk("R11 err 15", int'(rErr), 1);
    chk("R11 reads 15", rReads, 0);
    runOp(4'd2, 1'b0, 16'h0600, 8'h00, 8'h00, 0);
    chk("R11 err clears", int'(rErr), 0);
  endtask

  task automatic testLatency();
    lat = 3;
    runOp(4'd8, 1'b0, 16'h0810, 8'h00, 8'hFF, 0);
    expectAll("R13 slow memory", 16'h00EF, int'(rdByte(16'h00EF)), 16'h0812, 3);
    runOp(4'd11, 1'b0, 16'h0B00, 8'h00, 8'h20, 0);
    expectAll("R13 slow pointer", 16'h5698, int'(rdByte(16'h5698)), 16'h0B01, 4);
    lat = 0;
    chk("R13 request stable", stabErr, 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testNoOperand();
    testImmediate();
    testPage0();
    testWide();
    testPointer();
    testPreX();
    testPostY();
    testBranch();
    testRaw();
    testUnknown();
    testLatency();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule